// File: doc/BRIEF.md
# Shared Interrupt Distributor with Acknowledge and End-of-Interrupt

The block gathers level-sensitive request lines from peripherals and forwards each one that software has enabled to the IRQ output of every core it is routed to. Software configures it through a small word-addressed register bus. Two global switches gate all forwarding: one for distribution and one for the CPU side. There is a per-interrupt enable, kept in 32-bit words that are set and cleared with write-one semantics, and a per-interrupt routing byte that selects destination cores.

A core takes an interrupt by reading the acknowledge register. The read returns the lowest-numbered interrupt that qualifies for that core and moves it to the Active state. An Active interrupt is not offered again until software writes its ID to the end-of-interrupt register. Together with the live level of its line, each interrupt therefore moves through four states: inactive, pending, active, and active with a pending line.

Top module: `irq_dist`

## Requirements
- R1: After reset the distribution switch, the CPU switch, every enable bit and every routing byte are zero, and every `irq_o` bit is low.
- R2: An IRQ is forwarded, and an acknowledge can return a real ID, only while bit 0 at byte address 0x000 (distribution switch) and bit 0 at 0x004 (CPU switch) are both 1.
- R3: The enable for ID 32n+b is bit b of word n. Writing to 0x100+4n sets the bits written as 1, and writing to 0x180+4n clears them. Zero bits leave their enables unchanged. Reading either address returns the current enables.
- R4: The routing for ID 4n+k is byte k of the word at 0x800+4n. Bit c of that byte routes the interrupt to core c. Bits at or above the core count read back as zero.
- R5: Bit c of `irq_o` is high exactly when some interrupt has its line high, is enabled, is routed to core c and is not Active, with both switches on. The output follows a line change one clock later.
- R6: A read of 0x C00 (acknowledge) by core `core_i` returns, on `rdata_o` one clock later, the lowest qualifying ID for that core, and makes that interrupt Active.
- R7: An Active interrupt no longer drives `irq_o` and is skipped by later acknowledges, even while its line stays high.
- R8: When nothing qualifies for the reading core, the acknowledge returns 1023 and changes no interrupt state.
- R9: Writing an ID to 0xC04 (end-of-interrupt) clears that interrupt's Active state, so it is presented again if its line is still high. Writing an ID that is not Active, or is out of range, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_IRQ | Level-sensitive request lines, bit i is ID i |
| core_i | input | CW | Index of the core issuing the bus access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the clock after `rd_i` |
| irq_o | output | NUM_CORES | Per-core interrupt request |

## Verification
The bench builds the block at its defaults: 128 IDs and two cores. At that size every enable word and every routing word can be swept, and each ID can be taken one at a time through pending, acknowledge, the masked Active state, end-of-interrupt and release. Each ID is routed to a single core, so every acknowledge is also tried from the wrong core. Routing several IDs to both cores then exercises lowest-ID selection, disabled IDs, stray end-of-interrupt writes and spurious reads taken while a switch is off.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [11:0] A_DIST_CTL = 12'h000;
  localparam logic [11:0] A_CPU_CTL  = 12'h004;
  localparam logic [11:0] A_ACK      = 12'hC00;
  localparam logic [11:0] A_EOI      = 12'hC04;
  // addr[11:7] region selectors, addr[6:2] is the word index
  localparam logic [4:0] RG_SET_EN = 5'h02;
  localparam logic [4:0] RG_CLR_EN = 5'h03;
  localparam logic [4:0] RG_TGT    = 5'h10;
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 128,
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [11:0]                         addr_i,
  input  logic [31:0]                         wdata_i,
  output logic [31:0]                         rd_o,
  output logic                                dist_en_o,
  output logic                                cpu_en_o,
  output logic [NUM_IRQ-1:0]                  en_o,
  output logic [NUM_IRQ-1:0][NUM_CORES-1:0]   tgt_o
);
  localparam int unsigned EN_WORDS  = (NUM_IRQ + 31) / 32;
  localparam int unsigned TGT_WORDS = (NUM_IRQ + 3) / 4;
  localparam int unsigned EWB = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int unsigned TWB = (TGT_WORDS > 1) ? $clog2(TGT_WORDS) : 1;

  logic                              dist_q, cpu_q;
  logic [NUM_IRQ-1:0]                en_q;
  logic [NUM_IRQ-1:0][NUM_CORES-1:0] tgt_q;

  logic [4:0] region, word;
  logic       set_hit, clr_hit, tgt_hit;

  assign region  = addr_i[11:7];
  assign word    = addr_i[6:2];
  assign set_hit = wr_i && (region == RG_SET_EN);
  assign clr_hit = wr_i && (region == RG_CLR_EN);
  assign tgt_hit = wr_i && (region == RG_TGT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_q <= 1'b0;
      cpu_q  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_DIST_CTL) dist_q <= wdata_i[0];
      if (addr_i == A_CPU_CTL)  cpu_q  <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (set_hit && int'(word) == i / 32 && wdata_i[i % 32]) en_q[i] <= 1'b1;
        else if (clr_hit && int'(word) == i / 32 && wdata_i[i % 32]) en_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (tgt_hit && int'(word) == i / 4) tgt_q[i] <= wdata_i[(i % 4) * 8 +: NUM_CORES];
      end
    end
  end

  // readback views
  logic [EN_WORDS-1:0][31:0]  en_words;
  logic [TGT_WORDS-1:0][31:0] tgt_words;

  always_comb begin
    en_words  = '0;
    tgt_words = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      en_words[i / 32][i % 32] = en_q[i];
      tgt_words[i / 4][(i % 4) * 8 +: NUM_CORES] = tgt_q[i];
    end
  end

  always_comb begin
    rd_o = '0;
    if (addr_i == A_DIST_CTL) rd_o[0] = dist_q;
    if (addr_i == A_CPU_CTL)  rd_o[0] = cpu_q;
    if ((region == RG_SET_EN || region == RG_CLR_EN) && int'(word) < EN_WORDS)
      rd_o = en_words[word[EWB-1:0]];
    if (region == RG_TGT && int'(word) < TGT_WORDS)
      rd_o = tgt_words[word[TWB-1:0]];
  end

  assign dist_en_o = dist_q;
  assign cpu_en_o  = cpu_q;
  assign en_o      = en_q;
  assign tgt_o     = tgt_q;

  // a set-enable write never clears a bit
  p_set_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit |=> (($past(en_q) & ~en_q) == '0));
endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] src_i,
  input  logic               ack_fire_i,
  input  logic [ID_W-1:0]    ack_id_i,
  input  logic               eoi_fire_i,
  input  logic [ID_W-1:0]    eoi_id_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] active_o
);
  localparam int unsigned IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] src_q, active_q, set_v, clr_v;
  logic               eoi_ok;

  assign eoi_ok = eoi_fire_i && (int'(eoi_id_i) < NUM_IRQ);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (ack_fire_i) set_v[ack_id_i[IW-1:0]] = 1'b1;
    if (eoi_ok)     clr_v[eoi_id_i[IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      active_q <= '0;
    end else begin
      src_q    <= src_i;
      active_q <= (active_q & ~clr_v) | set_v;
    end
  end

  assign pend_o   = src_q;
  assign active_o = active_q;

  p_ack_sets_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire_i |=> active_q[$past(ack_id_i[IW-1:0])]);

  p_eoi_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_ok && !(ack_fire_i && ack_id_i == eoi_id_i)) |=> !active_q[$past(eoi_id_i[IW-1:0])]);

  p_active_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoi_fire_i |=> (($past(active_q) & ~active_q) == '0));
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 128,
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_CORES-1:0][NUM_IRQ-1:0]   cand_i,
  output logic [NUM_CORES-1:0]                any_o,
  output logic [NUM_CORES-1:0][ID_W-1:0]      id_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // lowest set index wins
    always_comb begin
      any_o[c] = 1'b0;
      id_o[c]  = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
        if (cand_i[c][i]) begin
          any_o[c] = 1'b1;
          id_o[c]  = ID_W'(i);
        end
      end
    end

    p_win_cand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o[c] |-> (int'(id_o[c]) < NUM_IRQ) && cand_i[c][id_o[c]]);
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 128,
  parameter int unsigned NUM_CORES = 2,
  localparam int unsigned CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   src_i,
  input  logic [CW-1:0]        core_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  logic                              dist_en, cpu_en, gate;
  logic [NUM_IRQ-1:0]                en, pend, active;
  logic [NUM_IRQ-1:0][NUM_CORES-1:0] tgt;
  logic [NUM_CORES-1:0][NUM_IRQ-1:0] cand;
  logic [NUM_CORES-1:0]              any;
  logic [NUM_CORES-1:0][ID_W-1:0]    win_id;
  logic [31:0]                       reg_rd, rdata_q;
  logic                              ack_rd, ack_fire, eoi_fire, core_ok;
  logic [ID_W-1:0]                   ack_id;

  irq_dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .rd_o(reg_rd), .dist_en_o(dist_en), .cpu_en_o(cpu_en), .en_o(en), .tgt_o(tgt)
  );

  assign gate = dist_en && cpu_en;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++)
      for (int i = 0; i < NUM_IRQ; i++)
        cand[c][i] = gate && pend[i] && en[i] && tgt[i][c] && !active[i];
  end

  irq_dist_arb #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) u_arb (
    .clk_i, .rst_ni, .cand_i(cand), .any_o(any), .id_o(win_id)
  );

  assign core_ok  = int'(core_i) < NUM_CORES;
  assign ack_rd   = rd_i && (addr_i == A_ACK);
  assign ack_fire = ack_rd && core_ok && any[core_i];
  assign ack_id   = core_ok ? win_id[core_i] : SPURIOUS_ID;
  assign eoi_fire = wr_i && (addr_i == A_EOI);

  irq_dist_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk_i, .rst_ni, .src_i,
    .ack_fire_i(ack_fire), .ack_id_i(ack_id),
    .eoi_fire_i(eoi_fire), .eoi_id_i(wdata_i[ID_W-1:0]),
    .pend_o(pend), .active_o(active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) begin
      if (ack_rd) rdata_q <= 32'(ack_fire ? ack_id : SPURIOUS_ID);
      else        rdata_q <= reg_rd;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
    assign irq_o[c] = |cand[c];
  end

  assign rdata_o = rdata_q;

  p_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !ack_fire) |=> (rdata_o == 32'(SPURIOUS_ID)) && $stable(active));

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate |-> !ack_fire);
endmodule

// File: tb/tb_irq_dist.sv
module tb_irq_dist;
  localparam int unsigned NI = 128;
  localparam int unsigned NC = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] src_i = '0;
  logic [0:0]    core_i = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NC-1:0] irq_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  irq_dist #(.NUM_IRQ(NI), .NUM_CORES(NC)) dut (
    .clk_i, .rst_ni, .src_i, .core_i, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input int c, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; core_i = 1'(c); rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_src(input logic [NI-1:0] v);
    @(negedge clk_i);
    src_i = v;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, pat;
    logic [NI-1:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    bus_rd(12'h000, 0, d); chk("R1 dist", d, 0);
    bus_rd(12'h004, 0, d); chk("R1 cpu", d, 0);
    for (int n = 0; n < 4; n++) begin bus_rd(12'h100 + 12'(4*n), 0, d); chk("R1 en", d, 0); end
    for (int n = 0; n < 32; n++) begin bus_rd(12'h800 + 12'(4*n), 0, d); chk("R1 tgt", d, 0); end
    bus_rd(12'hC00, 0, d); chk("R8 ack after reset", d, 1023);

    // R3 enable words
    for (int n = 0; n < 4; n++) begin
      pat = 32'hDEADBEEF ^ (32'(n) * 32'h1111_1111);
      bus_wr(12'h100 + 12'(4*n), pat);
      bus_rd(12'h100 + 12'(4*n), 0, d); chk("R3 set", d, pat);
      bus_rd(12'h180 + 12'(4*n), 0, d); chk("R3 read via clr", d, pat);
      bus_wr(12'h100 + 12'(4*n), 32'h0);
      bus_rd(12'h100 + 12'(4*n), 0, d); chk("R3 zero set", d, pat);
      bus_wr(12'h180 + 12'(4*n), pat & 32'h0000FFFF);
      bus_rd(12'h100 + 12'(4*n), 0, d); chk("R3 clr", d, pat & 32'hFFFF0000);
    end
    for (int n = 0; n < 4; n++) bus_wr(12'h180 + 12'(4*n), 32'hFFFF_FFFF);
    for (int n = 0; n < 4; n++) begin bus_rd(12'h100 + 12'(4*n), 0, d); chk("R3 all clr", d, 0); end

    // R4 target words
    for (int n = 0; n < 32; n++) begin
      pat = (32'(n) * 32'h0903_0507) ^ 32'hA55A_F00F;
      bus_wr(12'h800 + 12'(4*n), pat);
    end
    for (int n = 0; n < 32; n++) begin
      pat = (32'(n) * 32'h0903_0507) ^ 32'hA55A_F00F;
      bus_rd(12'h800 + 12'(4*n), 0, d); chk("R4 tgt", d, pat & 32'h0303_0303);
    end

    // per-id routing: even ids to core 0, odd ids to core 1
    for (int n = 0; n < 32; n++) bus_wr(12'h800 + 12'(4*n), 32'h0201_0201);
    for (int n = 0; n < 4; n++) bus_wr(12'h100 + 12'(4*n), 32'hFFFF_FFFF);

    // R2 gating
    v = '0; v[5] = 1'b1;
    set_src(v);
    chk("R2 none", 32'(irq_o), 0);
    bus_wr(12'h000, 1);
    chk("R2 dist only", 32'(irq_o), 0);
    bus_rd(12'hC00, 1, d); chk("R2 ack gated", d, 1023);
    bus_wr(12'h004, 1);
    chk("R2 both", 32'(irq_o), 32'h2);
    bus_wr(12'h000, 0);
    chk("R2 cpu only", 32'(irq_o), 0);
    bus_wr(12'h000, 1);
    set_src('0);

    // exhaustive per-id sweep
    for (int id = 0; id < NI; id++) begin
      int c;
      c = id % 2;
      v = '0; v[id] = 1'b1;
      set_src(v);
      chk("R5 irq on", 32'(irq_o), 32'(1 << c));
      bus_rd(12'hC00, 1 - c, d); chk("R8 wrong core", d, 1023);
      bus_rd(12'hC00, c, d); chk("R6 ack id", d, 32'(id));
      chk("R7 masked", 32'(irq_o), 0);
      bus_rd(12'hC00, c, d); chk("R7 not reoffered", d, 1023);
      bus_wr(12'hC04, 32'(id));
      chk("R9 reoffered", 32'(irq_o), 32'(1 << c));
      set_src('0);
      chk("R5 irq off", 32'(irq_o), 0);
    end

    // R6 lowest id wins, both cores
    for (int n = 0; n < 32; n++) bus_wr(12'h800 + 12'(4*n), 32'h0303_0303);
    v = '0; v[99] = 1'b1; v[97] = 1'b1; v[40] = 1'b1;
    set_src(v);
    chk("R5 both cores", 32'(irq_o), 3);
    bus_rd(12'hC00, 0, d); chk("R6 first", d, 40);
    bus_rd(12'hC00, 1, d); chk("R6 second", d, 97);
    bus_rd(12'hC00, 0, d); chk("R6 third", d, 99);
    bus_rd(12'hC00, 0, d); chk("R8 exhausted", d, 1023);
    chk("R7 all active", 32'(irq_o), 0);
    bus_wr(12'hC04, 97);
    chk("R9 one back", 32'(irq_o), 3);
    bus_rd(12'hC00, 1, d); chk("R6 again", d, 97);
    bus_wr(12'hC04, 98);
    bus_wr(12'hC04, 1000);
    chk("R9 stray eoi", 32'(irq_o), 0);
    bus_wr(12'hC04, 40);
    bus_wr(12'hC04, 97);
    bus_wr(12'hC04, 99);
    bus_wr(12'h180 + 12'h004, 32'h0000_0100); // disable id 40
    bus_rd(12'hC00, 0, d); chk("R3 disabled skipped", d, 97);
    bus_wr(12'hC04, 97);

    // R8 spurious leaves state
    bus_wr(12'h004, 0);
    bus_rd(12'hC00, 0, d); chk("R8 gated spurious", d, 1023);
    bus_wr(12'h004, 1);
    chk("R8 still pending", 32'(irq_o), 3);
    bus_rd(12'hC00, 0, d); chk("R8 not activated", d, 97);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule